// File: doc/BRIEF.md
# Hysteretic Buck Switch Controller

This block is the digital timing core of a hysteretic step-down converter. Three comparator results reach it as synchronous logic levels: the output is under its regulation threshold, the high-side current is over its limit, and the inductor current is under the zero-cross level. An enable completes the inputs. From these it drives gate commands for the high-side switch and for the low-side synchronous rectifier. Time is counted in cycles of a fast system clock.

No ramp or fixed period sets when conduction happens. Comparator events decide it, subject to counted minimum on-time and minimum off-time windows. A current-limit trip ends high-side conduction at once. Before the rectifier can drive current backwards it is released, which emulates a diode. A break-before-make gap separates the two gates every time one hands over to the other. Each time a new high-side conduction starts, a single-cycle marker pulses so the switching rate can be measured outside the block.

Top module: `hbuck_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released with enable low, `hs_gate`, `ls_gate` and `cycle_start` are all 0.
- R2: When enabled with both gates off and the minimum off-time elapsed, a cycle in which `fb_below` is 1 is followed one clock later by `hs_gate` = 1. `cycle_start` is 1 exactly in the first cycle of every high-side conduction and 0 in every other cycle.
- R3: If `fb_below` returns to 0 early, `hs_gate` still stays high for exactly `TON_CYC` cycles (no current-limit trip, enable held).
- R4: Once the minimum on-time has passed, `hs_gate` stays high for as long as `fb_below` is 1. It falls in the cycle after the first sample of `fb_below` = 0.
- R5: `hs_ilim` = 1 while `hs_gate` is high forces `hs_gate` low on the next cycle, even before `TON_CYC` cycles have elapsed.
- R6: After `hs_gate` falls, both gates stay low for `DEAD_CYC` cycles before `ls_gate` may rise.
- R7: `zc_below` = 1 while `ls_gate` is high turns `ls_gate` off on the next cycle. If `zc_below` is 1 when the post-conduction dead time ends, `ls_gate` does not rise in that off period.
- R8: Between the fall of `hs_gate` and its next rise, `hs_gate` stays low for at least `TOFF_CYC` cycles even when `fb_below` is held at 1. The gap is exactly `TOFF_CYC` when the rectifier has already stopped. It is `TOFF_CYC + DEAD_CYC` when the rectifier is still conducting, in which case `ls_gate` is high for `TOFF_CYC - DEAD_CYC` of those cycles.
- R9: When `ls_gate` hands over to `hs_gate`, both gates are low for `DEAD_CYC` cycles in between.
- R10: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R11: Enable low in one cycle makes both gates 0 from the next cycle on. While enable stays low, no gate rises and `cycle_start` stays 0. Re-enabling with `fb_below` = 1 starts a conduction one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable; 0 turns both gates off |
| fb_below | input | 1 | Output voltage under regulation threshold |
| hs_ilim | input | 1 | High-side current over limit |
| zc_below | input | 1 | Inductor current under rectifier-off threshold |
| hs_gate | output | 1 | High-side switch gate command |
| ls_gate | output | 1 | Low-side rectifier gate command |
| cycle_start | output | 1 | One-cycle pulse at each high-side turn-on |

## Verification
The bench first lets feedback recover one cycle into a conduction. A controller that honours no minimum would then show a one-cycle on pulse instead of `TON_CYC`. It also holds feedback low well past the minimum, to catch an on-time that is cut short or runs over by one. Current-limit trips are issued early in a conduction. There, a controller that waits for the on-time window would keep the switch on, and one without the off-time window would restart at once. The off gap is measured both with the rectifier conducting and with it already stopped by the zero-cross flag. An off-by-one in the dead-time or off-time counters, or a missing handover gap, shows up as a wrong gap length or as overlapping gates. Enable is dropped during high-side and low-side conduction to confirm both gates let go in the next cycle.

// File: rtl/hbuck_pkg.sv
package hbuck_pkg;

  // Conduction phases of the power stage.
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,  // disabled, both switches open
    PH_GAP_HI   = 3'd1,  // break-before-make before high-side
    PH_HIGH     = 3'd2,  // high-side conducting
    PH_GAP_LO   = 3'd3,  // break-before-make after high-side
    PH_LOW      = 3'd4,  // synchronous rectifier conducting
    PH_COAST    = 3'd5   // rectifier released, waiting for demand
  } phase_t;

  // Timer slot indices shared by the top and the phase machine.
  localparam int unsigned TMR_ON   = 0;
  localparam int unsigned TMR_OFF  = 1;
  localparam int unsigned TMR_GAP  = 2;
  localparam int unsigned TMR_NUM  = 3;

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/hbuck_interval.sv
// Loadable down-counter that flags when a minimum interval has elapsed.
module hbuck_interval #(
  parameter int unsigned WIDTH    = 4,
  parameter int unsigned LOAD_VAL = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);

  localparam logic [WIDTH-1:0] LOAD_L = WIDTH'(LOAD_VAL);

  logic [WIDTH-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= LOAD_L;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign done = (remain == '0);

  // Interval never exceeds its programmed length and counts down by one.
  assert_countdown_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && $past(remain) != '0) |-> (remain == $past(remain) - 1'b1));

  assert_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    remain <= LOAD_L);

endmodule

// File: rtl/hbuck_phase_fsm.sv
// Phase sequencer: decides each conduction phase from comparator levels
// and interval flags, and registers the gate commands.
module hbuck_phase_fsm
  import hbuck_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               fb_below,
  input  logic               hs_ilim,
  input  logic               zc_below,
  input  logic [TMR_NUM-1:0] tmr_done,
  output logic [TMR_NUM-1:0] tmr_load,
  output logic               hs_gate,
  output logic               ls_gate,
  output logic               cycle_start
);

  phase_t phase, phase_nx;
  logic   on_ok, off_ok, gap_ok;
  logic   want_high;

  assign on_ok  = tmr_done[TMR_ON];
  assign off_ok = tmr_done[TMR_OFF];
  assign gap_ok = tmr_done[TMR_GAP];

  // Demand for a new conduction: output low and off window elapsed.
  assign want_high = fb_below && off_ok;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: begin
        if (want_high) phase_nx = PH_HIGH;
      end
      PH_GAP_HI: begin
        if (gap_ok) phase_nx = PH_HIGH;
      end
      PH_HIGH: begin
        if (hs_ilim || (on_ok && !fb_below)) phase_nx = PH_GAP_LO;
      end
      PH_GAP_LO: begin
        if (gap_ok) phase_nx = zc_below ? PH_COAST : PH_LOW;
      end
      PH_LOW: begin
        if (want_high)     phase_nx = PH_GAP_HI;
        else if (zc_below) phase_nx = PH_COAST;
      end
      PH_COAST: begin
        if (want_high) phase_nx = PH_HIGH;
      end
      default: phase_nx = PH_IDLE;
    endcase
    if (!en) phase_nx = PH_IDLE;
  end

  // Interval loads happen on phase entry / exit.
  always_comb begin
    tmr_load          = '0;
    tmr_load[TMR_ON]  = (phase_nx == PH_HIGH) && (phase != PH_HIGH);
    tmr_load[TMR_OFF] = (phase == PH_HIGH) && (phase_nx != PH_HIGH);
    tmr_load[TMR_GAP] = ((phase_nx == PH_GAP_HI) && (phase != PH_GAP_HI)) ||
                        ((phase_nx == PH_GAP_LO) && (phase != PH_GAP_LO));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      hs_gate     <= 1'b0;
      ls_gate     <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      phase       <= phase_nx;
      hs_gate     <= (phase_nx == PH_HIGH);
      ls_gate     <= (phase_nx == PH_LOW);
      cycle_start <= (phase_nx == PH_HIGH) && (phase != PH_HIGH);
    end
  end

  // ---------------------------------------------------------------
  // Properties guarding the sequencer
  // ---------------------------------------------------------------
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  assert_ilim_cut_R5: assert property (@(posedge clk) disable iff (rst)
    (hs_gate && hs_ilim) |=> !hs_gate);

  assert_zc_release_R7: assert property (@(posedge clk) disable iff (rst)
    (ls_gate && zc_below) |=> !ls_gate);

  assert_hold_on_demand_R4: assert property (@(posedge clk) disable iff (rst)
    (hs_gate && fb_below && en && !hs_ilim) |=> hs_gate);

  assert_disable_off_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!hs_gate && !ls_gate && !cycle_start));

  assert_start_marks_rise_R2: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> (hs_gate && !$past(hs_gate)));

  assert_rise_marked_R2: assert property (@(posedge clk) disable iff (rst)
    (hs_gate && !$past(hs_gate)) |-> cycle_start);

  assert_gap_after_high_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> !$past(hs_gate));

  assert_gap_before_high_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> !$past(ls_gate));

  assert_phase_legal_R10: assert property (@(posedge clk) disable iff (rst)
    phase inside {PH_IDLE, PH_GAP_HI, PH_HIGH, PH_GAP_LO, PH_LOW, PH_COAST});

endmodule

// File: rtl/hbuck_ctrl.sv
// Top: hysteretic buck switch controller.
module hbuck_ctrl
  import hbuck_pkg::*;
#(
  parameter int unsigned TON_CYC  = 11,
  parameter int unsigned TOFF_CYC = 10,
  parameter int unsigned DEAD_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fb_below,
  input  logic hs_ilim,
  input  logic zc_below,
  output logic hs_gate,
  output logic ls_gate,
  output logic cycle_start
);

  localparam int unsigned MAX_CYC = max3(TON_CYC, TOFF_CYC, DEAD_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam int unsigned RUN_W   = $clog2(MAX_CYC + DEAD_CYC + 2) + 1;

  logic [TMR_NUM-1:0] tmr_load;
  logic [TMR_NUM-1:0] tmr_done;

  // One interval counter per timing rule; load value picked by slot.
  for (genvar g = 0; g < TMR_NUM; g++) begin : g_tmr
    localparam int unsigned LEN = (g == TMR_ON)  ? TON_CYC  :
                                  (g == TMR_OFF) ? TOFF_CYC : DEAD_CYC;
    hbuck_interval #(
      .WIDTH    (CNT_W),
      .LOAD_VAL (LEN - 1)
    ) u_tmr (
      .clk  (clk),
      .rst  (rst),
      .load (tmr_load[g]),
      .done (tmr_done[g])
    );
  end

  hbuck_phase_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .fb_below    (fb_below),
    .hs_ilim     (hs_ilim),
    .zc_below    (zc_below),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate),
    .cycle_start (cycle_start)
  );

  // ---------------------------------------------------------------
  // Run-length trackers for the minimum on/off window properties
  // ---------------------------------------------------------------
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] TON_L   = RUN_W'(TON_CYC);
  localparam logic [RUN_W-1:0] TOFF_L  = RUN_W'(TOFF_CYC);

  logic [RUN_W-1:0] hi_run, lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      lo_run <= RUN_MAX;
    end else begin
      hi_run <= !hs_gate ? '0 : ((hi_run == RUN_MAX) ? hi_run : hi_run + 1'b1);
      lo_run <= hs_gate  ? '0 : ((lo_run == RUN_MAX) ? lo_run : lo_run + 1'b1);
    end
  end

  assert_min_on_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(hs_gate) && $past(en) && !$past(hs_ilim)) |-> (hi_run >= TON_L));

  assert_min_off_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> (lo_run >= TOFF_L));

endmodule

// File: tb/hbuck_ctrl_test.sv
module hbuck_ctrl_test;

  localparam int TON  = 11;
  localparam int TOFF = 10;
  localparam int DEAD = 1;

  logic clk = 1'b0;
  logic rst, en, fb_below, hs_ilim, zc_below;
  logic hs_gate, ls_gate, cycle_start;

  int n_checks = 0;
  int n_fail   = 0;
  int overlap  = 0;
  int start_bad = 0;
  logic prev_hs = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hbuck_ctrl #(.TON_CYC(TON), .TOFF_CYC(TOFF), .DEAD_CYC(DEAD)) uut (
    .clk(clk), .rst(rst), .en(en), .fb_below(fb_below),
    .hs_ilim(hs_ilim), .zc_below(zc_below),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .cycle_start(cycle_start)
  );

  // Continuous monitors (R10 overlap, R2 start marker)
  always @(negedge clk) begin
    if (!rst) begin
      if (hs_gate && ls_gate) overlap++;
      if (cycle_start != (hs_gate && !prev_hs)) start_bad++;
    end
    prev_hs = hs_gate;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Settle into coast: no demand, rectifier released.
  task automatic settle();
    fb_below = 1'b0; hs_ilim = 1'b0; zc_below = 1'b1;
    repeat (TON + TOFF + 6) tick();
    zc_below = 1'b0;
  endtask

  task automatic test_reset();
    rst = 1'b1; en = 1'b0; fb_below = 1'b1; hs_ilim = 1'b0; zc_below = 1'b0;
    repeat (3) tick();
    check(!hs_gate && !ls_gate && !cycle_start, "R1 gates in reset",
          {hs_gate, ls_gate, cycle_start}, 0);
    rst = 1'b0;
    tick();
    check(!hs_gate && !ls_gate && !cycle_start, "R1 gates after reset",
          {hs_gate, ls_gate, cycle_start}, 0);
    fb_below = 1'b0;
  endtask

  task automatic test_min_on();
    int len;
    en = 1'b1;
    settle();
    fb_below = 1'b1;
    tick();
    check(hs_gate && cycle_start, "R2 turn-on and start pulse",
          {hs_gate, cycle_start}, 3);
    fb_below = 1'b0;
    len = 1;
    for (int i = 0; i < 100; i++) begin
      tick();
      if (i == 0) check(!cycle_start, "R2 start is single cycle", cycle_start, 0);
      if (hs_gate) len++; else break;
    end
    check(len == TON, "R3 minimum on-time", len, TON);
    check(!ls_gate, "R6 dead time after high-side", ls_gate, 0);
    tick();
    check(ls_gate, "R6 rectifier on after dead time", ls_gate, 1);
    zc_below = 1'b1;
    tick();
    check(!ls_gate && !hs_gate, "R7 rectifier released on zero-cross",
          {hs_gate, ls_gate}, 0);
  endtask

  task automatic test_extend();
    int len;
    settle();
    fb_below = 1'b1;
    tick();
    len = 1;
    for (int i = 0; i < 100; i++) begin
      if (len == TON + 5) fb_below = 1'b0;
      tick();
      if (hs_gate) len++; else break;
    end
    check(len == TON + 5, "R4 on-time follows demand", len, TON + 5);
  endtask

  task automatic test_ilim();
    settle();
    fb_below = 1'b1;
    tick();
    tick();
    tick();
    check(hs_gate, "R5 conducting before trip", hs_gate, 1);
    hs_ilim = 1'b1;
    tick();
    check(!hs_gate, "R5 current limit cuts early", hs_gate, 0);
    hs_ilim = 1'b0;
    fb_below = 1'b0;
  endtask

  task automatic measure_off(input bit coast, output int low, output int lsn,
                             output bit first_ls, output bit last_ls);
    settle();
    zc_below = coast;
    fb_below = 1'b1;
    tick();
    tick();
    hs_ilim = 1'b1;
    tick();
    hs_ilim = 1'b0;
    low = 1; lsn = 0; first_ls = ls_gate; last_ls = ls_gate;
    for (int i = 0; i < 100; i++) begin
      tick();
      if (!hs_gate) begin
        low++;
        if (ls_gate) lsn++;
        last_ls = ls_gate;
      end else break;
    end
    fb_below = 1'b0;
  endtask

  task automatic test_off_rectify();
    int low, lsn; bit f, l;
    measure_off(1'b0, low, lsn, f, l);
    check(low == TOFF + DEAD, "R8 off gap with rectifier", low, TOFF + DEAD);
    check(lsn == TOFF - DEAD, "R8 rectifier conduction length", lsn, TOFF - DEAD);
    check(!f, "R6 no rectifier right after high-side", f, 0);
    check(!l, "R9 dead time before high-side", l, 0);
  endtask

  task automatic test_off_coast();
    int low, lsn; bit f, l;
    measure_off(1'b1, low, lsn, f, l);
    check(low == TOFF, "R8 off gap when coasting", low, TOFF);
    check(lsn == 0, "R7 rectifier suppressed by zero-cross", lsn, 0);
  endtask

  task automatic test_disable();
    int bad;
    settle();
    fb_below = 1'b1;
    tick();
    tick();
    en = 1'b0;
    tick();
    check(!hs_gate && !ls_gate, "R11 disable drops high-side",
          {hs_gate, ls_gate}, 0);
    bad = 0;
    repeat (20) begin
      tick();
      if (hs_gate || ls_gate || cycle_start) bad++;
    end
    check(bad == 0, "R11 quiet while disabled", bad, 0);
    en = 1'b1;
    tick();
    check(hs_gate && cycle_start, "R11 restart on re-enable",
          {hs_gate, cycle_start}, 3);
    fb_below = 1'b0;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (ls_gate) break;
    end
    check(ls_gate, "R11 rectifier reached", ls_gate, 1);
    en = 1'b0;
    tick();
    check(!ls_gate && !hs_gate, "R11 disable drops rectifier",
          {hs_gate, ls_gate}, 0);
    en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_min_on();
    test_extend();
    test_ilim();
    test_off_rectify();
    test_off_coast();
    test_disable();
    repeat (5) tick();
    check(overlap == 0, "R10 gates never overlap", overlap, 0);
    check(start_bad == 0, "R2 start marker matches rises", start_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule